// File: doc/BRIEF.md
# Random Word Collector with Repetition Health Test

The block takes one raw entropy bit at a time from an external noise input and builds 32-bit random words. It samples at a reduced rate: one bit every `DIV` clock cycles, with `DIV` set to 32 by default. The first sampled bit of each word lands in bit 0. Finished words are placed in a small first-in-first-out queue, four words deep by default. A streaming consumer, such as a DMA channel, drains the queue through a valid/ready read port.

A health test watches every finished word and compares it with the word finished just before it. If two consecutive words are identical, the test fails. A failure sets a sticky error flag, empties the queue and stops all further output until software pulses the clear input.

After reset, and again after each clear, the first finished word only sets the comparison reference and is never delivered. An enable input gates sampling. When the queue is full, sampling pauses without losing any bits.

Top module: `rng_collect`

## Requirements
- R1: After reset, `rd_valid_o`, `err_o` and `full_o` are low.
- R2: While sampling is allowed, `raw_bit_i` is sampled once every `DIV` clock cycles. A word is finished after `WORD_W` samples, and the first sampled bit ends up in bit 0.
- R3: The first word finished after reset, and the first word finished after an error clear, is used only as the comparison reference and never appears on `rd_data_o`.
- R4: Every later finished word that differs from the word finished before it is queued. Queued words are delivered in the order they were finished.
- R5: The queue holds up to `DEPTH` words, and `full_o` is high exactly when `DEPTH` words are held. While the queue is full, sampling pauses. The partly built word is kept, so no bit is lost.
- R6: `rd_valid_o` is high exactly when the queue is not empty and `err_o` is low. A word leaves the queue only in a cycle where `rd_valid_o` and `rd_ready_i` are both high. `rd_data_o` holds steady while the consumer stalls.
- R7: A finished word equal to the previous finished word sets `err_o` on the next clock edge. That same edge empties the queue. `err_o` then stays high and `rd_valid_o` stays low.
- R8: Pulsing `clr_err_i` while `err_o` is high drops `err_o` on the next edge. Sampling then restarts from an empty partial word.
- R9: Driving `en_i` low discards the partly built word and restarts the sample divider. It leaves queued words untouched, and they remain readable.
- R10: A word that is queued in the same cycle as another word is read out is kept. Both actions take effect and the queue level stays the same.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Synchronous reset, active low |
| en_i | input | 1 | Sampling enable; low discards the partial word |
| raw_bit_i | input | 1 | Raw entropy bit |
| clr_err_i | input | 1 | Clears the sticky health error |
| rd_ready_i | input | 1 | Consumer accepts a word |
| rd_valid_o | output | 1 | A word is available |
| rd_data_o | output | WORD_W | Head word of the queue |
| err_o | output | 1 | Sticky health-test failure |
| full_o | output | 1 | Queue holds DEPTH words |

## Verification
Two functions can fall in the same cycle. First, a finished word can be written into the queue in the very cycle the consumer takes the head word. The bench provokes this by raising `rd_ready_i` only in the cycles where its model predicts a queue write while the queue already holds a word. It judges the result by the model's per-clock match of level, head data and `full_o`, and it requires that such collisions actually occurred. Second, a health failure can flush the queue while a word is being read out. The bench queues words and then feeds a repeated pattern, and it expects the flush to win: the queue ends empty and `rd_valid_o` stays low.

// File: rtl/rng_pkg.sv
// Package: shared widths and types of the random word collector.
// Assumes: every module of the collector imports it for the word type.
package rng_pkg;
    parameter int unsigned RNG_WORD_W = 32;
    parameter int unsigned RNG_DIV    = 32;
    parameter int unsigned RNG_DEPTH  = 4;

    typedef logic [RNG_WORD_W-1:0] rng_word_t;
endpackage

// File: rtl/rng_strobe.sv
// Module: sample strobe divider. While run_i is high it counts clock
// cycles and pulses strobe_o once every DIV cycles. A low run_i holds the
// count (pause); drop_i returns the count to zero (restart).
// Assumes: DIV >= 2; drop_i and run_i are never high together.
module rng_strobe #(
    parameter int unsigned DIV = 32
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run_i,
    input  logic drop_i,
    output logic strobe_o
);
    localparam int unsigned CW = (DIV > 2) ? $clog2(DIV) : 1;
    localparam logic [CW-1:0] LAST = CW'(DIV - 1);

    logic [CW-1:0] cnt_q;

    // Strobe on the last count of an active period.
    always_comb begin
        strobe_o = run_i && (cnt_q == LAST);
    end

    // Cycle counter: restart on drop, hold on pause, wrap at LAST.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (drop_i) begin
            cnt_q <= '0;
        end else if (run_i) begin
            if (cnt_q == LAST) begin
                cnt_q <= '0;
            end else begin
                cnt_q <= cnt_q + CW'(1);
            end
        end
    end
endmodule

// File: rtl/rng_packer.sv
// Module: word packer. On each strobe it shifts one raw bit in at the top,
// so the first bit of a word ends in bit 0. After W bits it presents the
// finished word with a one-cycle valid pulse.
// Assumes: strobe_i and drop_i are never high together.
module rng_packer
    import rng_pkg::*;
#(
    parameter int unsigned W = RNG_WORD_W
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         drop_i,
    input  logic         strobe_i,
    input  logic         bit_i,
    output logic         word_vld_o,
    output logic [W-1:0] word_o
);
    localparam int unsigned NW = $clog2(W);
    localparam logic [NW-1:0] LAST_BIT = NW'(W - 1);

    logic [W-1:0]  shift_q;
    logic [W-1:0]  shift_nxt;
    logic [NW-1:0] nbits_q;
    logic [W-1:0]  word_q;
    logic          vld_q;

    // Next shift value: new bit enters at the top.
    always_comb begin
        shift_nxt = {bit_i, shift_q[W-1:1]};
    end

    // Shift register and fill counter; a full word is registered out.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            shift_q <= '0;
            nbits_q <= '0;
            word_q  <= '0;
            vld_q   <= 1'b0;
        end else begin
            vld_q <= 1'b0;
            if (drop_i) begin
                nbits_q <= '0;
            end else if (strobe_i) begin
                shift_q <= shift_nxt;
                if (nbits_q == LAST_BIT) begin
                    nbits_q <= '0;
                    word_q  <= shift_nxt;
                    vld_q   <= 1'b1;
                end else begin
                    nbits_q <= nbits_q + NW'(1);
                end
            end
        end
    end

    assign word_vld_o = vld_q;
    assign word_o     = word_q;
endmodule

// File: rtl/rng_health.sv
// Module: repetition health test. Compares every finished word with the
// previous one. The first word after reset or clear only arms the
// reference. A match sets a sticky error; other words are passed on.
// Assumes: word_vld_i is never high in two consecutive cycles.
module rng_health
    import rng_pkg::*;
#(
    parameter int unsigned W = RNG_WORD_W
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         word_vld_i,
    input  logic [W-1:0] word_i,
    input  logic         clr_i,
    output logic         push_o,
    output logic         fail_o,
    output logic         err_o
);
    logic [W-1:0] ref_q;
    logic         ref_vld_q;
    logic         err_q;
    logic         same;

    // Decide whether a finished word passes, fails or only arms.
    always_comb begin
        same   = (word_i == ref_q);
        fail_o = word_vld_i && ref_vld_q && same;
        push_o = word_vld_i && ref_vld_q && !same && !err_q;
    end

    // Reference word register and its valid flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ref_q     <= '0;
            ref_vld_q <= 1'b0;
        end else if (err_q && clr_i) begin
            ref_vld_q <= 1'b0;
        end else if (word_vld_i) begin
            ref_q     <= word_i;
            ref_vld_q <= 1'b1;
        end
    end

    // Sticky error: set on failure, cleared only by the clear input.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            err_q <= 1'b0;
        end else if (fail_o) begin
            err_q <= 1'b1;
        end else if (clr_i) begin
            err_q <= 1'b0;
        end
    end

    assign err_o = err_q;
endmodule

// File: rtl/rng_fifo.sv
// Module: small synchronous queue with flush. Push and pop may occur in
// the same cycle; flush overrides both and empties the queue.
// Assumes: push_i is never high while full; pop_i never while empty.
module rng_fifo
    import rng_pkg::*;
#(
    parameter int unsigned W     = RNG_WORD_W,
    parameter int unsigned DEPTH = RNG_DEPTH
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         push_i,
    input  logic [W-1:0] data_i,
    input  logic         pop_i,
    input  logic         flush_i,
    output logic [W-1:0] head_o,
    output logic         empty_o,
    output logic         full_o
);
    localparam int unsigned PW = (DEPTH > 2) ? $clog2(DEPTH) : 1;
    localparam int unsigned CW = $clog2(DEPTH + 1);
    localparam logic [PW-1:0] LAST_PTR = PW'(DEPTH - 1);
    localparam logic [CW-1:0] FULL_CNT = CW'(DEPTH);

    logic [W-1:0]  mem_q [DEPTH];
    logic [PW-1:0] wr_q;
    logic [PW-1:0] rd_q;
    logic [CW-1:0] cnt_q;

    // One storage register per slot, written when the pointer selects it.
    for (genvar i = 0; i < DEPTH; i++) begin : g_slot
        always_ff @(posedge clk) begin
            if (push_i && !flush_i && (wr_q == PW'(i))) begin
                mem_q[i] <= data_i;
            end
        end
    end

    // Pointer and level bookkeeping, flush first.
    always_ff @(posedge clk) begin
        if (!rst_n || flush_i) begin
            wr_q  <= '0;
            rd_q  <= '0;
            cnt_q <= '0;
        end else begin
            if (push_i) begin
                wr_q <= (wr_q == LAST_PTR) ? '0 : wr_q + PW'(1);
            end
            if (pop_i) begin
                rd_q <= (rd_q == LAST_PTR) ? '0 : rd_q + PW'(1);
            end
            cnt_q <= cnt_q + CW'(push_i) - CW'(pop_i);
        end
    end

    // Status and head word.
    always_comb begin
        head_o  = mem_q[rd_q];
        empty_o = (cnt_q == '0);
        full_o  = (cnt_q == FULL_CNT);
    end
endmodule

// File: rtl/rng_collect.sv
// Module: random word collector top. Samples the raw bit input at a
// divided rate, packs words, runs the repetition test and queues
// passing words for a valid/ready consumer.
// Assumes: raw_bit_i is synchronous to clk; clr_err_i is a pulse.
module rng_collect
    import rng_pkg::*;
#(
    parameter int unsigned WORD_W = RNG_WORD_W,
    parameter int unsigned DIV    = RNG_DIV,
    parameter int unsigned DEPTH  = RNG_DEPTH
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en_i,
    input  logic              raw_bit_i,
    input  logic              clr_err_i,
    input  logic              rd_ready_i,
    output logic              rd_valid_o,
    output logic [WORD_W-1:0] rd_data_o,
    output logic              err_o,
    output logic              full_o
);
    logic              run;
    logic              drop;
    logic              strobe;
    logic              word_vld;
    logic [WORD_W-1:0] word;
    logic              push;
    logic              fail;
    logic              err;
    logic              pop;
    logic              empty;
    logic              full;
    logic [WORD_W-1:0] head;

    // Sampling gate: pause when full, restart on disable or error.
    always_comb begin
        run  = en_i && !full && !err;
        drop = !en_i || err;
    end

    // Read handshake and outputs.
    always_comb begin
        rd_valid_o = !empty && !err;
        pop        = rd_valid_o && rd_ready_i;
        rd_data_o  = head;
        err_o      = err;
        full_o     = full;
    end

    rng_strobe #(.DIV(DIV)) u_strobe (
        .clk      (clk),
        .rst_n    (rst_n),
        .run_i    (run),
        .drop_i   (drop),
        .strobe_o (strobe)
    );

    rng_packer #(.W(WORD_W)) u_packer (
        .clk        (clk),
        .rst_n      (rst_n),
        .drop_i     (drop),
        .strobe_i   (strobe),
        .bit_i      (raw_bit_i),
        .word_vld_o (word_vld),
        .word_o     (word)
    );

    rng_health #(.W(WORD_W)) u_health (
        .clk        (clk),
        .rst_n      (rst_n),
        .word_vld_i (word_vld),
        .word_i     (word),
        .clr_i      (clr_err_i),
        .push_o     (push),
        .fail_o     (fail),
        .err_o      (err)
    );

    rng_fifo #(.W(WORD_W), .DEPTH(DEPTH)) u_fifo (
        .clk     (clk),
        .rst_n   (rst_n),
        .push_i  (push),
        .data_i  (word),
        .pop_i   (pop),
        .flush_i (fail),
        .head_o  (head),
        .empty_o (empty),
        .full_o  (full)
    );
endmodule

// File: rtl/rng_collect_chk.sv
// Module: property checker for the collector, attached by bind.
// Assumes: connected only to ports of rng_collect.
module rng_collect_chk #(
    parameter int unsigned W = 32
) (
    input logic         clk,
    input logic         rst_n,
    input logic         clr_err_i,
    input logic         rd_ready_i,
    input logic         rd_valid_o,
    input logic [W-1:0] rd_data_o,
    input logic         err_o,
    input logic         full_o
);
    // R6
    valid_no_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid_o |-> !err_o);

    // R6
    hold_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_valid_o && !rd_ready_i) |=> (!rd_valid_o || $stable(rd_data_o)));

    // R7
    err_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (err_o && !clr_err_i) |=> err_o);

    // R7
    flush_on_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(err_o) |-> (!full_o && !rd_valid_o));

    // R8
    err_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (err_o && clr_err_i) |=> !err_o);

    // R5
    full_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (full_o && !rd_ready_i && !err_o) |=> (full_o || err_o));
endmodule

bind rng_collect rng_collect_chk #(.W(WORD_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .clr_err_i  (clr_err_i),
    .rd_ready_i (rd_ready_i),
    .rd_valid_o (rd_valid_o),
    .rd_data_o  (rd_data_o),
    .err_o      (err_o),
    .full_o     (full_o)
);

// File: tb/rng_collect_test.sv
// Bench: behavioural reference model of the collector, compared with the
// design on every clock, plus directed checks on each requirement.
module rng_collect_test;
    localparam int CLK_PERIOD = 10;
    localparam int W     = 32;
    localparam int DIV   = 32;
    localparam int DEPTH = 4;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         en_i = 1'b0;
    logic         raw_bit_i = 1'b0;
    logic         clr_err_i = 1'b0;
    logic         rd_ready_i = 1'b0;
    logic         rd_valid_o;
    logic [W-1:0] rd_data_o;
    logic         err_o;
    logic         full_o;

    int n_checks = 0;
    int n_fail   = 0;
    bit finished = 0;
    bit use_pat  = 0;
    logic [W-1:0] pat = '0;

    // Reference model state.
    int           m_cnt, m_nbits, m_words;
    logic [W-1:0] m_sh, m_word, m_ref;
    bit           m_wvld, m_refv, m_err;
    logic [W-1:0] m_q[$];

    rng_collect uut (
        .clk        (clk),
        .rst_n      (rst_n),
        .en_i       (en_i),
        .raw_bit_i  (raw_bit_i),
        .clr_err_i  (clr_err_i),
        .rd_ready_i (rd_ready_i),
        .rd_valid_o (rd_valid_o),
        .rd_data_o  (rd_data_o),
        .err_o      (err_o),
        .full_o     (full_o)
    );

    always #(CLK_PERIOD / 2) clk = ~clk;

    task automatic check(input bit ok, input string tag,
                         input logic [W-1:0] act, input logic [W-1:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wrap_up();
        if (!finished) begin
            finished = 1;
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    endtask

    // Reference model: next state from requirements, per clock.
    always @(posedge clk) begin
        if (!rst_n) begin
            m_cnt = 0; m_nbits = 0; m_words = 0; m_sh = '0; m_word = '0;
            m_ref = '0; m_wvld = 0; m_refv = 0; m_err = 0; m_q.delete();
        end else begin
            bit run, strobe, pop, fail, push, nw;
            logic [W-1:0] nxt;
            run    = en_i && (m_q.size() < DEPTH) && !m_err;
            strobe = run && (m_cnt == DIV - 1);
            pop    = (m_q.size() > 0) && !m_err && rd_ready_i;
            fail   = m_wvld && m_refv && (m_word == m_ref);
            push   = m_wvld && m_refv && (m_word != m_ref) && !m_err;
            if (fail) m_q.delete();
            else begin
                if (pop) void'(m_q.pop_front());
                if (push) m_q.push_back(m_word);
            end
            if (m_err && clr_err_i) m_refv = 0;
            else if (m_wvld) begin m_ref = m_word; m_refv = 1; end
            nxt = {raw_bit_i, m_sh[W-1:1]};
            nw  = 0;
            if (!en_i || m_err) begin
                m_cnt = 0; m_nbits = 0;
            end else if (run) begin
                m_cnt = (m_cnt == DIV - 1) ? 0 : m_cnt + 1;
                if (strobe) begin
                    m_sh = nxt;
                    if (m_nbits == W - 1) begin
                        m_nbits = 0; m_word = nxt; nw = 1; m_words++;
                    end else m_nbits++;
                end
            end
            m_wvld = nw;
            if (fail) m_err = 1;
            else if (clr_err_i) m_err = 0;
        end
    end

    // Per-clock comparison, then raw bit drive for the next edge.
    always @(negedge clk) begin
        if (rst_n && !finished) begin
            bit mv;
            mv = (m_q.size() > 0) && !m_err;
            check(rd_valid_o == mv, "R6 valid", W'(rd_valid_o), W'(mv));
            if (mv) check(rd_data_o == m_q[0], "R4 head data", rd_data_o, m_q[0]);
            check(err_o == m_err, "R7 err", W'(err_o), W'(m_err));
            check(full_o == (m_q.size() == DEPTH), "R5 full",
                  W'(full_o), W'(m_q.size() == DEPTH));
        end
        raw_bit_i <= use_pat ? pat[m_nbits] : 1'($urandom);
    end

    task automatic cycles(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic wait_words(input int n);
        int target;
        target = m_words + n;
        while (m_words < target) @(negedge clk);
        cycles(2);
    endtask

    task automatic pop_one();
        rd_ready_i = 1'b1;
        @(negedge clk);
        rd_ready_i = 1'b0;
        cycles(1);
    endtask

    // Watchdog.
    initial begin
        repeat (190000) @(posedge clk);
        n_checks++; n_fail++;
        $display("FAIL watchdog expired");
        wrap_up();
    end

    initial begin
        int coll;
        cycles(3);
        rst_n = 1'b1;
        cycles(1);
        // R1 reset state
        check(!rd_valid_o && !err_o && !full_o, "R1 reset outputs",
              W'({rd_valid_o, err_o, full_o}), '0);

        // R5 fill the queue (reference word plus DEPTH words), then pause.
        en_i = 1'b1;
        wait_words(DEPTH + 1);
        check(full_o == 1'b1, "R5 full after DEPTH words", W'(full_o), 1);
        cycles(3 * DIV * W);
        check(full_o && !err_o, "R5 still full while paused", W'(full_o), 1);
        rd_ready_i = 1'b1;
        while (rd_valid_o) @(negedge clk);
        rd_ready_i = 1'b0;

        // R2 bit order: a single leading 1 must land in bit 0.
        use_pat = 1; pat = 32'h0000_0001;
        wait_words(1);
        check(rd_valid_o && rd_data_o == 32'h0000_0001, "R2 LSB first",
              rd_data_o, 32'h0000_0001);
        pat = 32'hC0DE_1235;
        wait_words(1);
        pop_one();
        check(rd_valid_o && rd_data_o == 32'hC0DE_1235, "R4 order", rd_data_o,
              32'hC0DE_1235);
        pop_one();

        // R7 repeated word: error, flush, no output.
        pat = 32'h5A5A_0F0F;
        wait_words(2);
        check(err_o && !rd_valid_o && !full_o, "R7 error flushes",
              W'({err_o, rd_valid_o, full_o}), 32'h4);
        cycles(200);
        check(err_o && !rd_valid_o, "R7 error sticky", W'(err_o), 1);

        // R8 clear, R3 reference word after clear is not delivered.
        pat = 32'h1357_9BDF;
        clr_err_i = 1'b1;
        @(negedge clk);
        clr_err_i = 1'b0;
        @(negedge clk);
        check(!err_o, "R8 clear drops error", W'(err_o), 0);
        wait_words(1);
        check(!rd_valid_o, "R3 reference word withheld", W'(rd_valid_o), 0);
        pat = 32'hFEDC_0123;
        wait_words(1);
        check(rd_valid_o && rd_data_o == 32'hFEDC_0123, "R3 next word delivered",
              rd_data_o, 32'hFEDC_0123);

        // R9 disable mid-word discards the partial word, keeps the queue.
        pat = 32'h8421_7E7E;
        cycles(20 * DIV + 5);
        en_i = 1'b0;
        cycles(10);
        check(rd_valid_o && rd_data_o == 32'hFEDC_0123, "R9 queue kept",
              rd_data_o, 32'hFEDC_0123);
        en_i = 1'b1;
        wait_words(1);
        pop_one();
        check(rd_valid_o && rd_data_o == 32'h8421_7E7E, "R9 partial discarded",
              rd_data_o, 32'h8421_7E7E);

        // R10 read in the same cycle as a queue write.
        use_pat = 0;
        coll = 0;
        for (int i = 0; i < 12 * DIV * W; i++) begin
            rd_ready_i = m_wvld && (m_q.size() > 0);
            if (rd_ready_i) coll++;
            @(negedge clk);
        end
        rd_ready_i = 1'b0;
        check(coll >= 10, "R10 collisions seen", W'(coll), 10);
        check(rd_valid_o && !err_o, "R10 word kept", W'(rd_valid_o), 1);

        // R6 random consumer stalls.
        for (int i = 0; i < 6000; i++) begin
            rd_ready_i = ($urandom % 40) == 0;
            @(negedge clk);
        end
        rd_ready_i = 1'b0;
        cycles(2);
        wrap_up();
    end
endmodule